// File: doc/BRIEF.md
# Strobe-Pin DRAM Command Formatter

This block issues DRAM commands to a memory device that has no command/address bus. It takes abstract commands (opcode, bank, row, column) into a short queue. Each command leaves the queue on one of two routes. The wide route drives a 32-bit word on the 16 shared data/command pins in a single clock, one half on the rising edge and one half on the falling edge. A one-clock strobe pulse marks that word. The narrow route shifts a 16-bit word out on the single strobe pin, two bits per clock, over eight clocks.

The route depends on the transfer state. While a data burst holds the data pins (`xfer_busy` high), only commands that the narrow route can carry may leave: activate, precharge, refresh and the read/write toggle. A precharge queued during a burst therefore goes out on the strobe pin as soon as it reaches the head of the queue. Commands that need the wide route wait at the head until the burst ends. With no burst in progress, every command takes the wide route.

Both outputs are presented as rising/falling pairs per clock for a DDR output stage placed outside this block. The bit encodings are placeholders.

Top module: `lpdram_cmd_tx`

## Requirements
- R1: While `rst_n` is low and in the first clock after its release: `in_ready` is 1, and `cd_oe`, `stb_rise`, `stb_fall` and `ser_busy` are 0.
- R2: The queue holds 4 commands. `in_ready` goes low only when the queue is full. A command offered while `in_ready` is low is dropped and never sent. Commands leave in arrival order.
- R3: With `xfer_busy` low in the issue clock, the head command of any opcode leaves on the wide route.
- R4: With `xfer_busy` high in the issue clock, a head command with opcode ACT=0, PRE=3, REF=4 or TOG=5 leaves on the strobe-pin route.
- R5: With `xfer_busy` high, a head command with opcode RD=1, WR=2, MRW=6 or NOP=7 stays in the queue and produces no output until `xfer_busy` is low.
- R6: A wide command drives `cd_oe` high for exactly one clock, starting the clock after it issues. The word is {op[2:0], bank[2:0], row[12:0], col[9:0], 3'b000}. `cd_rise` carries bits 31:16 and `cd_fall` carries bits 15:0. In that same clock `stb_rise` is 1 and `stb_fall` is 0.
- R7: A strobe-pin command is the word {op[2:0], bank[2:0], row[9:0]}, sent MSB first. In clock k (k = 0..7) after the load, `stb_rise` carries bit 15-2k and `stb_fall` carries bit 14-2k. `ser_busy` is high for exactly those 8 clocks.
- R8: No strobe-pin command starts while `ser_busy` is high, so consecutive strobe-pin words are separated by at least one clock with `ser_busy` low. `cd_oe` is never high while `ser_busy` is high.
- R9: When neither route is presenting a command, `stb_rise`, `stb_fall` and `cd_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | A command is offered |
| in_ready | output | 1 | The queue can accept a command |
| in_op | input | 3 | Opcode |
| in_bank | input | 3 | Bank address |
| in_row | input | 13 | Row address |
| in_col | input | 10 | Column address |
| xfer_busy | input | 1 | A data burst currently holds the data pins |
| cd_oe | output | 1 | Output enable for the data/command pins |
| cd_rise | output | 16 | Data/command pins, rising-edge half |
| cd_fall | output | 16 | Data/command pins, falling-edge half |
| stb_rise | output | 1 | Strobe pin, rising-edge bit |
| stb_fall | output | 1 | Strobe pin, falling-edge bit |
| ser_busy | output | 1 | A strobe-pin word is being shifted out |

## Verification
Both routes want the strobe pin: a wide command needs its marker pulse there, while a narrow command needs it for eight clocks of shifting. A clash can arise when a burst ends while a precharge is still shifting and a write waits behind it. The bench provokes this by queuing a precharge and a write during a burst, then dropping `xfer_busy` one clock after the strobe-pin word starts. The scoreboard then demands that the full 16-bit precharge word arrives intact, and that the write's wide word and marker pulse appear only after `ser_busy` has fallen.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  localparam int OP_W      = 3;
  localparam int BANK_W    = 3;
  localparam int ROW_W     = 13;
  localparam int COL_W     = 10;
  localparam int PAR_W     = 32;
  localparam int SER_W     = 16;
  localparam int PAD_W     = PAR_W - OP_W - BANK_W - ROW_W - COL_W;
  localparam int SER_ROW_W = SER_W - OP_W - BANK_W;

  typedef enum logic [OP_W-1:0] {
    OP_ACT = 3'd0,
    OP_RD  = 3'd1,
    OP_WR  = 3'd2,
    OP_PRE = 3'd3,
    OP_REF = 3'd4,
    OP_TOG = 3'd5,
    OP_MRW = 3'd6,
    OP_NOP = 3'd7
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
  } cmd_t;

  // Opcodes that the strobe-pin route can carry
  function automatic logic ser_capable(op_e op);
    return (op == OP_ACT) || (op == OP_PRE) || (op == OP_REF) || (op == OP_TOG);
  endfunction

  function automatic logic [PAR_W-1:0] par_encode(cmd_t c);
    return {c.op, c.bank, c.row, c.col, {PAD_W{1'b0}}};
  endfunction

  function automatic logic [SER_W-1:0] ser_encode(cmd_t c);
    return {c.op, c.bank, c.row[SER_ROW_W-1:0]};
  endfunction

endpackage

// File: rtl/lpc_cmd_fifo.sv
module lpc_cmd_fifo
  import lpc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  cmd_t                         din,
  input  logic                         pop,
  output cmd_t                         head,
  output logic                         have_cmd,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  cmd_t          mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = bump(wr_q);
    if (pop)  rd_d = bump(rd_q);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  assign head     = mem[rd_q];
  assign have_cmd = (cnt_q != '0);
  assign full     = (cnt_q == CW'(DEPTH));
  assign count    = cnt_q;

endmodule

// File: rtl/lpc_route_sel.sv
module lpc_route_sel
  import lpc_pkg::*;
#(
  parameter bit SERIAL_EN = 1'b1
) (
  input  logic have_cmd,
  input  op_e  head_op,
  input  logic xfer_busy,
  input  logic ser_busy,
  output logic issue_par,
  output logic issue_ser
);

  // The strobe pin is shared: nothing issues while a serial word shifts
  assign issue_par = have_cmd && !xfer_busy && !ser_busy;

  generate
    if (SERIAL_EN) begin : g_ser
      assign issue_ser = have_cmd && xfer_busy && !ser_busy && ser_capable(head_op);
    end else begin : g_noser
      assign issue_ser = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/lpc_par_fmt.sv
module lpc_par_fmt
  import lpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  cmd_t             cmd,
  output logic             oe,
  output logic [PAR_W/2-1:0] rise,
  output logic [PAR_W/2-1:0] fall,
  output logic             stb
);

  logic             oe_q, oe_d;
  logic [PAR_W-1:0] word_q, word_d;
  logic             word_en;

  always_comb begin
    oe_d    = issue;
    word_en = issue;
    word_d  = par_encode(cmd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      word_q <= '0;
    end else begin
      oe_q <= oe_d;
      if (word_en) word_q <= word_d;
    end
  end

  assign oe   = oe_q;
  assign rise = word_q[PAR_W-1:PAR_W/2];
  assign fall = word_q[PAR_W/2-1:0];
  assign stb  = oe_q;

endmodule

// File: rtl/lpc_ser_fmt.sv
module lpc_ser_fmt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word,
  output logic         busy,
  output logic         bit_r,
  output logic         bit_f
);

  localparam int CLKS = W / 2;
  localparam int CW   = $clog2(CLKS + 1);

  logic [W-1:0]  sr_q, sr_d;
  logic [CW-1:0] left_q, left_d;

  always_comb begin
    sr_d   = sr_q;
    left_d = left_q;
    if (load) begin
      sr_d   = word;
      left_d = CW'(CLKS);
    end else if (left_q != '0) begin
      sr_d   = {sr_q[W-3:0], 2'b00};
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      left_q <= '0;
    end else begin
      sr_q   <= sr_d;
      left_q <= left_d;
    end
  end

  assign busy  = (left_q != '0);
  assign bit_r = busy & sr_q[W-1];
  assign bit_f = busy & sr_q[W-2];

endmodule

// File: rtl/lpdram_cmd_tx.sv
module lpdram_cmd_tx
  import lpc_pkg::*;
#(
  parameter int QDEPTH    = 4,
  parameter bit SERIAL_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [2:0]  in_op,
  input  logic [2:0]  in_bank,
  input  logic [12:0] in_row,
  input  logic [9:0]  in_col,
  input  logic        xfer_busy,
  output logic        cd_oe,
  output logic [15:0] cd_rise,
  output logic [15:0] cd_fall,
  output logic        stb_rise,
  output logic        stb_fall,
  output logic        ser_busy
);

  localparam int QCW = $clog2(QDEPTH + 1);

  cmd_t           in_cmd, head;
  logic           push, pop, have_cmd, full;
  logic [QCW-1:0] fifo_cnt;
  logic           issue_par, issue_ser;
  logic           par_stb, ser_r, ser_f;

  assign in_cmd.op   = op_e'(in_op);
  assign in_cmd.bank = in_bank;
  assign in_cmd.row  = in_row;
  assign in_cmd.col  = in_col;

  assign in_ready = !full;
  assign push     = in_valid && !full;
  assign pop      = issue_par || issue_ser;

  lpc_cmd_fifo #(.DEPTH(QDEPTH)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .din      (in_cmd),
    .pop      (pop),
    .head     (head),
    .have_cmd (have_cmd),
    .full     (full),
    .count    (fifo_cnt)
  );

  lpc_route_sel #(.SERIAL_EN(SERIAL_EN)) u_sel (
    .have_cmd  (have_cmd),
    .head_op   (head.op),
    .xfer_busy (xfer_busy),
    .ser_busy  (ser_busy),
    .issue_par (issue_par),
    .issue_ser (issue_ser)
  );

  lpc_par_fmt u_par (
    .clk   (clk),
    .rst_n (rst_n),
    .issue (issue_par),
    .cmd   (head),
    .oe    (cd_oe),
    .rise  (cd_rise),
    .fall  (cd_fall),
    .stb   (par_stb)
  );

  lpc_ser_fmt #(.W(SER_W)) u_ser (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (issue_ser),
    .word  (ser_encode(head)),
    .busy  (ser_busy),
    .bit_r (ser_r),
    .bit_f (ser_f)
  );

  assign stb_rise = par_stb | ser_r;
  assign stb_fall = ser_f;

endmodule

// File: rtl/lpdram_cmd_tx_chk.sv
module lpdram_cmd_tx_chk #(
  parameter int QDEPTH = 4,
  parameter int SCLKS  = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic                       xfer_busy,
  input logic                       cd_oe,
  input logic                       stb_rise,
  input logic                       stb_fall,
  input logic                       ser_busy,
  input logic [$clog2(QDEPTH+1)-1:0] fifo_cnt
);

  localparam int RW = $clog2(SCLKS + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (ser_busy) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (fifo_cnt <= $past(fifo_cnt))); // R2
  AST_WIDE_NOT_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    cd_oe |-> $past(!xfer_busy)); // R5
  AST_NARROW_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_busy) |-> $past(xfer_busy)); // R4
  AST_WIDE_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
    cd_oe |-> (stb_rise && !stb_fall)); // R6
  AST_NARROW_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_busy) |-> (run_q == RW'(SCLKS))); // R7
  AST_NO_ROUTE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(cd_oe && ser_busy)); // R8
  AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cd_oe && !ser_busy) |-> (!stb_rise && !stb_fall)); // R9

endmodule

bind lpdram_cmd_tx lpdram_cmd_tx_chk #(.QDEPTH(QDEPTH), .SCLKS(lpc_pkg::SER_W/2)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .xfer_busy (xfer_busy),
  .cd_oe     (cd_oe),
  .stb_rise  (stb_rise),
  .stb_fall  (stb_fall),
  .ser_busy  (ser_busy),
  .fifo_cnt  (fifo_cnt)
);

// File: tb/lpdram_cmd_tx_bench.sv
`timescale 1ns/1ps
module lpdram_cmd_tx_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [2:0]  in_op;
  logic [2:0]  in_bank;
  logic [12:0] in_row;
  logic [9:0]  in_col;
  logic        xfer_busy;
  logic        cd_oe;
  logic [15:0] cd_rise, cd_fall;
  logic        stb_rise, stb_fall, ser_busy;

  always #2.5 clk = ~clk;

  lpdram_cmd_tx u_lpdram_cmd_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_bank(in_bank), .in_row(in_row), .in_col(in_col),
    .xfer_busy(xfer_busy), .cd_oe(cd_oe), .cd_rise(cd_rise), .cd_fall(cd_fall),
    .stb_rise(stb_rise), .stb_fall(stb_fall), .ser_busy(ser_busy)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [32:0] exp_q [$];   // bit 32: 1 = wide route
  int          ser_n = 0;
  logic [15:0] ser_acc = '0;
  logic        prev_xfer = 1'b0;
  logic        ser_done_prev = 1'b0;
  int          cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [32:0] act, input logic [32:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wide_word(logic [2:0] op, logic [2:0] b,
                                            logic [12:0] r, logic [9:0] c);
    return {op, b, r, c, 3'b000};
  endfunction

  function automatic logic [15:0] narrow_word(logic [2:0] op, logic [2:0] b,
                                              logic [12:0] r);
    return {op, b, r[9:0]};
  endfunction

  // Driver: offers one command, records the expected output when accepted
  task automatic push(input logic [2:0] op, input logic [2:0] b,
                      input logic [12:0] r, input logic [9:0] c, input bit wide);
    bit acc;
    @(posedge clk); #1;
    in_op = op; in_bank = b; in_row = r; in_col = c; in_valid = 1'b1;
    forever begin
      @(negedge clk); acc = in_ready;
      @(posedge clk);
      if (acc) break;
    end
    #1 in_valid = 1'b0;
    if (wide) exp_q.push_back({1'b1, wide_word(op, b, r, c)});
    else      exp_q.push_back({1'b0, 16'h0, narrow_word(op, b, r)});
  endtask

  task automatic set_xfer(input logic v);
    @(posedge clk); #1 xfer_busy = v;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || ser_n != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    logic [32:0] e;
    if (rst_n) begin
      if (cd_oe) begin
        chk(!ser_busy, "R8", "wide word during strobe shift", 33'(ser_busy), 33'h0);
        chk(!prev_xfer, "R5", "wide word issued during burst", 33'(prev_xfer), 33'h0);
        chk(stb_rise && !stb_fall, "R6", "marker pulse", {31'h0, stb_rise, stb_fall}, 33'h2);
        if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected wide word", {1'b1, cd_rise, cd_fall}, 33'h0);
        else begin
          e = exp_q.pop_front();
          chk(e == {1'b1, cd_rise, cd_fall}, "R6", "wide word / route (R3)", {1'b1, cd_rise, cd_fall}, e);
        end
      end
      if (ser_busy) begin
        if (ser_n == 0) begin
          chk(prev_xfer, "R4", "narrow word outside burst", 33'(prev_xfer), 33'h1);
          chk(!ser_done_prev, "R8", "no gap between narrow words", 33'(ser_done_prev), 33'h0);
        end
        ser_acc = {ser_acc[13:0], stb_rise, stb_fall};
        ser_n++;
        ser_done_prev = 1'b0;
        if (ser_n == 8) begin
          ser_n = 0;
          ser_done_prev = 1'b1;
          if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected narrow word", {17'h0, ser_acc}, 33'h0);
          else begin
            e = exp_q.pop_front();
            chk(e == {17'h0, ser_acc}, "R7", "narrow word / route (R4)", {17'h0, ser_acc}, e);
          end
        end
      end else begin
        chk(ser_n == 0, "R7", "narrow word length", 33'(ser_n), 33'h0);
        ser_n = 0;
        ser_done_prev = 1'b0;
        if (!cd_oe) chk(!stb_rise && !stb_fall && !cd_oe, "R9", "idle pins",
                        {30'h0, cd_oe, stb_rise, stb_fall}, 33'h0);
      end
      prev_xfer = xfer_busy;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; xfer_busy = 1'b0;
    in_op = '0; in_bank = '0; in_row = '0; in_col = '0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk(in_ready && !cd_oe && !stb_rise && !stb_fall && !ser_busy, "R1", "reset pins",
        {28'h0, in_ready, cd_oe, stb_rise, stb_fall, ser_busy}, 33'h10);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !cd_oe && !stb_rise && !stb_fall && !ser_busy, "R1", "after release",
        {28'h0, in_ready, cd_oe, stb_rise, stb_fall, ser_busy}, 33'h10);

    // R3: no burst, every opcode takes the wide route
    push(3'd6, 3'd1, 13'h1ABC, 10'h2F1, 1'b1);
    push(3'd0, 3'd7, 13'h0F0F, 10'h155, 1'b1);
    push(3'd1, 3'd2, 13'h1FFF, 10'h3FF, 1'b1);
    push(3'd2, 3'd5, 13'h0001, 10'h000, 1'b1);
    push(3'd4, 3'd0, 13'h1234, 10'h0AA, 1'b1);
    drain();

    // R4, R7, R8: burst active, strobe-route commands back to back
    set_xfer(1'b1);
    push(3'd0, 3'd3, 13'h02A5, 10'h011, 1'b0);
    push(3'd3, 3'd6, 13'h1155, 10'h022, 1'b0);
    push(3'd4, 3'd1, 13'h03FF, 10'h033, 1'b0);
    push(3'd5, 3'd7, 13'h0200, 10'h044, 1'b0);
    drain();

    // R5, R2: wide-only commands wait during a burst and fill the queue
    push(3'd1, 3'd0, 13'h0111, 10'h101, 1'b1);
    push(3'd2, 3'd1, 13'h0222, 10'h202, 1'b1);
    push(3'd6, 3'd2, 13'h0333, 10'h303, 1'b1);
    push(3'd7, 3'd3, 13'h0444, 10'h004, 1'b1);
    @(negedge clk);
    chk(!in_ready, "R2", "ready low when full", 33'(in_ready), 33'h0);
    chk(!cd_oe && !ser_busy, "R5", "held during burst", {31'h0, cd_oe, ser_busy}, 33'h0);
    @(posedge clk); #1;
    in_op = 3'd2; in_bank = 3'd4; in_row = 13'h0DED; in_col = 10'h1EE; in_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!in_ready, "R2", "ready low while offered", 33'(in_ready), 33'h0);
    end
    @(posedge clk); #1 in_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 4, "R5", "nothing sent during burst", 33'(exp_q.size()), 33'h4);
    set_xfer(1'b0);
    drain();
    chk(in_ready, "R2", "ready after drain", 33'(in_ready), 33'h1);

    // R8: burst ends while a precharge shifts and a write waits behind it
    set_xfer(1'b1);
    push(3'd3, 3'd5, 13'h03C3, 10'h0, 1'b0);
    push(3'd2, 3'd5, 13'h0777, 10'h3C3, 1'b1);
    while (!ser_busy) @(negedge clk);
    set_xfer(1'b0);
    drain();

    chk(exp_q.size() == 0, "R2", "scoreboard empty", 33'(exp_q.size()), 33'h0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule